// File: doc/BRIEF.md
# Next Program-Counter Address Logic

This block works out the following instruction's word address in a single-cycle processor with 32-bit byte addresses. The program counter is held as a 30-bit word address, which is byte-address bits 31:2. Each cycle the block picks one of five update paths:

- plain increment;
- increment plus a sign-extended branch offset;
- a pseudo-direct jump that keeps the top four bits of the current counter;
- a jump to the value of register rs;
- a fixed entry address for system calls.

The branch test uses the ALU's zero and sign flags together with a branch kind code. A small registered counter with reset comes with the block, so the next-address result can be watched as it is loaded.

The decoder drives a 2-bit source select and a 2-bit branch kind. The datapath supplies the 16-bit offset, the 26-bit jump target, register rs and the two ALU flags. `pc_next` is the combinational result. `pc_q` takes that value on every rising clock edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low the counter `pc_q` holds the parameter RESET_WORD (default 30'h0000_1000).
- R2: With source select 2'b00 and branch kind 2'b00 (no branch), the next word is `pc_q + 1`, modulo 2^30.
- R3: With source select 2'b00 and branch kind 2'b01 (less than zero), the branch is taken when `alu_neg` is 1. A taken branch gives `pc_q + 1 + sext(br_off)`. With `alu_neg` 0 the result is `pc_q + 1`.
- R4: With source select 2'b00 and branch kind 2'b10 (equal), the branch is taken when `alu_zero` is 1. Otherwise the result is `pc_q + 1`.
- R5: With source select 2'b00 and branch kind 2'b11 (not equal), the branch is taken when `alu_zero` is 0. Otherwise the result is `pc_q + 1`.
- R6: The 16-bit offset is sign-extended, so an offset with bit 15 set moves the counter backwards.
- R7: Source select 2'b01 gives `{pc_q[29:26], jmp_tgt}`.
- R8: Source select 2'b10 gives `rs_val[31:2]`.
- R9: Source select 2'b11 gives the parameter SYS_WORD (default 30'h0000_0020).
- R10: When source select is not 2'b00, the branch kind and the ALU flags have no effect on the result.
- R11: `pc_next` is combinational from the inputs and `pc_q`, and `pc_q` loads `pc_next` at every rising clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_sel | input | 2 | Source select: 00 increment/branch, 01 jump, 10 register, 11 system call |
| br_kind | input | 2 | Branch kind: 00 none, 01 less than zero, 10 equal, 11 not equal |
| alu_zero | input | 1 | ALU result is zero |
| alu_neg | input | 1 | ALU result is negative |
| br_off | input | 16 | Branch offset in words, two's complement |
| jmp_tgt | input | 26 | Jump target word bits |
| rs_val | input | 32 | Register rs value (byte address) |
| pc_next | output | 30 | Next word address (combinational) |
| pc_q | output | 30 | Registered word program counter |

## Verification
`pc_next` depends only on the current inputs and `pc_q`, so it is due in the same cycle the inputs are applied. The bench drives inputs on the falling edge and compares `pc_next` 1 ns later. `pc_q` shows that value one rising edge later, and the bench compares it at the next falling edge, where the behavioural model also moves its own counter forward. The embedded properties compare `pc_q` one cycle after each select and branch combination with values they rebuild from the sampled inputs.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      SEL_SEQ = 2'b00,
      SEL_JMP = 2'b01,
      SEL_REG = 2'b10,
      SEL_SYS = 2'b11
   } pc_sel_e;

   typedef enum logic [1:0] {
      BR_NONE = 2'b00,
      BR_LTZ  = 2'b01,
      BR_EQ   = 2'b10,
      BR_NE   = 2'b11
   } br_kind_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
(
   input  br_kind_e kind,
   input  logic     zero_flag,
   input  logic     neg_flag,
   output logic     taken
);
   always_comb begin
      unique case (kind)
         BR_LTZ:  taken = neg_flag;
         BR_EQ:   taken = zero_flag;
         BR_NE:   taken = ~zero_flag;
         default: taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_incr.sv
module npc_incr #(
   parameter int WORD_W = 30,
   parameter int OFF_W  = 16,
   parameter bit SHARED = 1'b1
) (
   input  logic [WORD_W-1:0] pc_word,
   input  logic [OFF_W-1:0]  offset,
   input  logic              take,
   output logic [WORD_W-1:0] step_word
);
   localparam int EXT_W = WORD_W - OFF_W;

   logic [WORD_W-1:0] off_ext;
   assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};

   if (OFF_W > WORD_W) begin : g_bad_off
      $error("npc_incr: OFF_W must not exceed WORD_W");
   end

   if (SHARED) begin : g_one_adder
      logic [WORD_W-1:0] addend;
      assign addend    = take ? off_ext : '0;
      assign step_word = pc_word + WORD_W'(1) + addend;
   end else begin : g_two_adders
      logic [WORD_W-1:0] inc_word;
      logic [WORD_W-1:0] tgt_word;
      assign inc_word  = pc_word + WORD_W'(1);
      assign tgt_word  = inc_word + off_ext;
      assign step_word = take ? tgt_word : inc_word;
   end
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int                 ADDR_W   = 32,
   parameter int                 TGT_W    = 26,
   parameter logic [ADDR_W-3:0]  SYS_WORD = '0
) (
   input  pc_sel_e           sel,
   input  logic [ADDR_W-3:0] step_word,
   input  logic [ADDR_W-3:0] pc_word,
   input  logic [TGT_W-1:0]  tgt,
   input  logic [ADDR_W-1:0] rs,
   output logic [ADDR_W-3:0] nxt
);
   localparam int WORD_W = ADDR_W - 2;
   localparam int KEEP_W = WORD_W - TGT_W;

   if (TGT_W >= WORD_W) begin : g_bad_tgt
      $error("npc_select: TGT_W must be below the word width");
   end

   logic [WORD_W-1:0] jmp_word;
   assign jmp_word = {pc_word[WORD_W-1 -: KEEP_W], tgt};

   logic unused_rs_low;
   assign unused_rs_low = ^rs[1:0];

   always_comb begin
      unique case (sel)
         SEL_JMP: nxt = jmp_word;
         SEL_REG: nxt = rs[ADDR_W-1:2];
         SEL_SYS: nxt = SYS_WORD;
         default: nxt = step_word;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                OFF_W      = 16,
   parameter int                TGT_W      = 26,
   parameter bit                SHARED_ADD = 1'b1,
   parameter logic [ADDR_W-3:0] RESET_WORD = 30'h0000_1000,
   parameter logic [ADDR_W-3:0] SYS_WORD   = 30'h0000_0020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        pc_sel,
   input  logic [1:0]        br_kind,
   input  logic              alu_zero,
   input  logic              alu_neg,
   input  logic [OFF_W-1:0]  br_off,
   input  logic [TGT_W-1:0]  jmp_tgt,
   input  logic [ADDR_W-1:0] rs_val,
   output logic [ADDR_W-3:0] pc_next,
   output logic [ADDR_W-3:0] pc_q
);
   localparam int WORD_W = ADDR_W - 2;
   localparam int KEEP_W = WORD_W - TGT_W;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("npc_unit: ADDR_W too small");
   end

   pc_sel_e           sel_e;
   br_kind_e          kind_e;
   logic              br_taken;
   logic [WORD_W-1:0] step_word;

   assign sel_e  = pc_sel_e'(pc_sel);
   assign kind_e = br_kind_e'(br_kind);

   npc_cond u_cond (
      .kind      (kind_e),
      .zero_flag (alu_zero),
      .neg_flag  (alu_neg),
      .taken     (br_taken)
   );

   npc_incr #(
      .WORD_W (WORD_W),
      .OFF_W  (OFF_W),
      .SHARED (SHARED_ADD)
   ) u_incr (
      .pc_word   (pc_q),
      .offset    (br_off),
      .take      (br_taken),
      .step_word (step_word)
   );

   npc_select #(
      .ADDR_W   (ADDR_W),
      .TGT_W    (TGT_W),
      .SYS_WORD (SYS_WORD)
   ) u_sel (
      .sel       (sel_e),
      .step_word (step_word),
      .pc_word   (pc_q),
      .tgt       (jmp_tgt),
      .rs        (rs_val),
      .nxt       (pc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= RESET_WORD;
      else        pc_q <= pc_next;
   end

   AST_RESET_LOAD: assert property (@(posedge clk)
      !rst_n |=> pc_q == RESET_WORD); // R1

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_sel == 2'b00 && br_kind == 2'b00) |=> pc_q == $past(pc_q) + WORD_W'(1)); // R2

   AST_LTZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_sel == 2'b00 && br_kind == 2'b01 && alu_neg)
      |=> pc_q == $past(pc_q) + WORD_W'(1) + WORD_W'($signed($past(br_off)))); // R3

   AST_EQ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_sel == 2'b00 && br_kind == 2'b10 && !alu_zero)
      |=> pc_q == $past(pc_q) + WORD_W'(1)); // R4

   AST_NE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_sel == 2'b00 && br_kind == 2'b11 && alu_zero)
      |=> pc_q == $past(pc_q) + WORD_W'(1)); // R5

   AST_JUMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel == 2'b01 |=> pc_q[WORD_W-1 -: KEEP_W] == $past(pc_q[WORD_W-1 -: KEEP_W])
                          && pc_q[TGT_W-1:0] == $past(jmp_tgt)); // R7

   AST_REG_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel == 2'b10 |=> pc_q == $past(rs_val[ADDR_W-1:2])); // R8

   AST_SYS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel == 2'b11 |=> pc_q == SYS_WORD); // R9

   AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pc_q == $past(pc_next)); // R11
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
   localparam logic [29:0] RST_W = 30'h0000_1000;
   localparam logic [29:0] SYS_W = 30'h0000_0020;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  pc_sel = 2'b00;
   logic [1:0]  br_kind = 2'b00;
   logic        alu_zero = 1'b0;
   logic        alu_neg = 1'b0;
   logic [15:0] br_off = '0;
   logic [25:0] jmp_tgt = '0;
   logic [31:0] rs_val = '0;
   logic [29:0] pc_next;
   logic [29:0] pc_q;

   int n_checks = 0;
   int n_fail = 0;
   logic [29:0] model_pc;

   always #2.5 clk = ~clk;

   npc_unit uut (
      .clk(clk), .rst_n(rst_n), .pc_sel(pc_sel), .br_kind(br_kind),
      .alu_zero(alu_zero), .alu_neg(alu_neg), .br_off(br_off),
      .jmp_tgt(jmp_tgt), .rs_val(rs_val), .pc_next(pc_next), .pc_q(pc_q)
   );

   task automatic check(input string req, input logic [29:0] act, input logic [29:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [29:0] ref_next(input logic [29:0] pc, input logic [1:0] s,
                                            input logic [1:0] k, input logic z, input logic n,
                                            input logic [15:0] o, input logic [25:0] t,
                                            input logic [31:0] r);
      int  off_i;
      bit  tk;
      if (s == 2'b01) return {pc[29:26], t};
      if (s == 2'b10) return r[31:2];
      if (s == 2'b11) return SYS_W;
      tk = (k == 2'b01 && n) || (k == 2'b10 && z) || (k == 2'b11 && !z);
      off_i = $signed(o);
      if (tk) return 30'(int'(pc) + 1 + off_i);
      return pc + 30'd1;
   endfunction

   function automatic string req_of(input logic [1:0] s, input logic [1:0] k);
      if (s == 2'b01) return "R7";
      if (s == 2'b10) return "R8";
      if (s == 2'b11) return "R9";
      case (k)
         2'b01:   return "R3";
         2'b10:   return "R4";
         2'b11:   return "R5";
         default: return "R2";
      endcase
   endfunction

   task automatic step(input logic [1:0] s, input logic [1:0] k, input logic z, input logic n,
                       input logic [15:0] o, input logic [25:0] t, input logic [31:0] r,
                       input string tag);
      logic [29:0] exp;
      string req;
      pc_sel = s; br_kind = k; alu_zero = z; alu_neg = n;
      br_off = o; jmp_tgt = t; rs_val = r;
      exp = ref_next(model_pc, s, k, z, n, o, t, r);
      req = (tag != "") ? tag : req_of(s, k);
      #1;
      check({req, " comb"}, pc_next, exp);
      @(negedge clk);
      check({"R11 ", req}, pc_q, exp);
      model_pc = exp;
   endtask

   initial begin
      #(200000 * 5);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", pc_q, RST_W);
      rst_n = 1'b1;
      model_pc = RST_W;
      step(2'b00, 2'b00, 0, 0, 16'h0000, '0, '0, "");
      step(2'b00, 2'b00, 1, 1, 16'h7FFF, '0, '0, "");
      step(2'b00, 2'b01, 0, 1, 16'h0010, '0, '0, "");
      step(2'b00, 2'b01, 1, 0, 16'h0010, '0, '0, "");
      step(2'b00, 2'b10, 1, 0, 16'h0100, '0, '0, "");
      step(2'b00, 2'b10, 0, 1, 16'h0100, '0, '0, "");
      step(2'b00, 2'b11, 0, 0, 16'h0004, '0, '0, "");
      step(2'b00, 2'b11, 1, 0, 16'h0004, '0, '0, "");
      step(2'b00, 2'b10, 1, 0, 16'hFFFD, '0, '0, "R6");
      step(2'b00, 2'b01, 0, 1, 16'hFFFF, '0, '0, "R6");
      step(2'b00, 2'b11, 0, 0, 16'h8000, '0, '0, "R6");
      step(2'b10, 2'b00, 0, 0, '0, '0, 32'hF000_0040, "");
      step(2'b01, 2'b00, 0, 0, '0, 26'h155_5555, '0, "");
      step(2'b01, 2'b10, 1, 1, 16'h0040, 26'h000_0100, '0, "R10");
      step(2'b10, 2'b11, 0, 1, 16'hFFF0, '0, 32'h0000_0403, "R10");
      step(2'b11, 2'b01, 1, 1, 16'h1234, '0, '0, "");
      step(2'b00, 2'b10, 1, 0, 16'hFFFE, '0, '0, "R6");
      step(2'b00, 2'b00, 0, 0, '0, '0, '0, "");
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, b;
         a = $urandom; b = $urandom;
         step(a[1:0], a[3:2], a[4], a[5], b[15:0], b[31:6], $urandom, "");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule